// File: doc/BRIEF.md
# Sound CPU Bus and Reset Arbiter

This block sits between a main processor and a secondary sound processor. The main processor has two control writes. One raises or drops a bus request. The other holds the sound processor in reset or lets it run. The block keeps a two-bit state from these writes. Bit 0 is set while the sound processor is out of reset, and bit 1 is set while the bus is requested. From that state the block derives the outputs below:

- a grant that opens the sound-side memory to the main processor;
- one-clock reset pulses for the sound processor and the FM synthesis chip;
- a level that holds the FM chip stopped;
- a pulse asking the sound processor model to catch up when it stops;
- a resume pulse with an aligned cycle count for when it starts again.

The main processor supplies its current master-clock count with every control write. When the sound processor restarts, that count is rounded up to the next multiple of 15 and handed out as the point from which the sound processor resumes. While no grant is held, host reads of the sound area return a fixed open-bus value, and host writes never reach the sound memory.

Top module: `snd_bus_arbiter`

## Requirements
- R1: After reset the state is 0, grant is low, all pulses are low, `fm_hold` is high and `resume_cycle` is 0.
- R2: A request write with `req_val`=1 sets state bit 1. From state 1 it moves to state 3, raises the grant and pulses `snd_stop` for one clock.
- R3: A request write with `req_val`=0 clears state bit 1. From state 3 it moves to state 1, drops the grant and pulses `resume_pulse`. From any other state it pulses nothing.
- R4: With each `resume_pulse`, `resume_cycle` holds the smallest multiple of 15 that is not below `cycle_now` as sampled with the write, for example 0→0, 15→15, 16→30, 1048574→1048575. Between resume pulses it keeps its value.
- R5: A run write with `run_val`=1 from state 0 gives the following: state 1, a one-clock pulse on both `snd_cpu_rst` and `fm_rst`, and a `resume_pulse`.
- R6: A run write with `run_val`=1 from state 2 gives state 3, the grant, and the `snd_cpu_rst`/`fm_rst` pulses, but no `resume_pulse`.
- R7: A run write with `run_val`=1 while bit 0 is already set leaves the state unchanged and pulses nothing.
- R8: A run write with `run_val`=0 clears bit 0 and raises `fm_hold`. From state 3 it drops the grant. From state 1 it pulses `snd_stop`.
- R9: `host_grant` is high exactly when state is 3. It changes on the same clock edge that takes the control write.
- R10: While `host_grant` is low, `host_rd_data` equals OPEN_VALUE (default 8'hFF) and `snd_wr_en` stays low. While it is high, `host_rd_data` follows `snd_rd_data` and `snd_wr_en` follows `host_wr_en`.
- R11: When both writes come in one cycle, the request write is applied first and the run write acts on its result. Events from both steps are all reported.
- R12: `snd_cpu_rst`, `fm_rst`, `snd_stop` and `resume_pulse` each last exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_we | input | 1 | Bus-request register write strobe |
| req_val | input | 1 | 1 = request bus, 0 = release |
| run_we | input | 1 | Sound reset register write strobe |
| run_val | input | 1 | 1 = release reset, 0 = hold in reset |
| cycle_now | input | CW | Main master-clock count at the write |
| snd_rd_data | input | DW | Read data from sound memory |
| host_wr_en | input | 1 | Host write strobe to the sound area |
| host_rd_data | output | DW | Read data returned to the host |
| snd_wr_en | output | 1 | Gated write strobe to sound memory |
| arb_state | output | 2 | State: bit 0 running, bit 1 requested |
| host_grant | output | 1 | Host owns the sound bus |
| snd_running | output | 1 | Sound processor is executing (state 1) |
| snd_cpu_rst | output | 1 | One-clock sound processor reset |
| fm_rst | output | 1 | One-clock FM chip reset |
| fm_hold | output | 1 | FM chip stopped |
| snd_stop | output | 1 | One-clock catch-up request when sound processor stops |
| resume_pulse | output | 1 | One-clock restart marker |
| resume_cycle | output | CW+1 | Aligned cycle count for the restart |

## Verification
A control write that is driven before a clock edge shows its effect on `arb_state`, `host_grant`, every pulse and `resume_cycle` just after that one edge. There is one register stage in the path and nothing sits beyond it. The host read and write gating is combinational on the registered grant, so it is checked in the same cycle as a grant that is already settled. The bench drives inputs on the falling edge and samples on the next falling edge. The pulse-length checks take one more sample a full cycle later, when the pulses must have gone low again.

// File: rtl/snd_arb_pkg.sv
package snd_arb_pkg;

    typedef logic [1:0] arb_st_t;

    localparam arb_st_t ST_HELD   = 2'd0;
    localparam arb_st_t ST_RUN    = 2'd1;
    localparam arb_st_t ST_REQRST = 2'd2;
    localparam arb_st_t ST_GRANT  = 2'd3;

    typedef struct packed {
        arb_st_t st;
        logic    stop;
        logic    restart;
        logic    cpu_rst;
    } step_t;

    typedef struct packed {
        arb_st_t st;
        logic    grant;
        logic    running;
        logic    cpu_rst;
        logic    stop;
        logic    restart;
        logic    fm_hold;
    } fsm_reg_t;

    // bus-request write applied to a state
    function automatic step_t apply_req(arb_st_t s, logic want);
        step_t r;
        r = '0;
        if (want) begin
            r.stop = (s == ST_RUN);
            r.st   = s | 2'b10;
        end else begin
            r.restart = (s == ST_GRANT);
            r.st      = s & 2'b01;
        end
        return r;
    endfunction

    // reset-line write applied to a state
    function automatic step_t apply_run(arb_st_t s, logic release_rst);
        step_t r;
        r = '0;
        if (release_rst) begin
            r.cpu_rst = (s == ST_HELD) || (s == ST_REQRST);
            r.restart = (s == ST_HELD);
            r.st      = s | 2'b01;
        end else begin
            r.stop = (s == ST_RUN);
            r.st   = s & 2'b10;
        end
        return r;
    endfunction

endpackage

// File: rtl/snd_arb_fsm.sv
module snd_arb_fsm
    import snd_arb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_we,
    input  logic    req_val,
    input  logic    run_we,
    input  logic    run_val,
    output logic    restart_now,
    output arb_st_t state,
    output logic    grant,
    output logic    running,
    output logic    cpu_rst,
    output logic    stop,
    output logic    restart,
    output logic    fm_hold
);

    fsm_reg_t r_d, r_q;
    step_t    s1, s2;

    always_comb begin
        s1 = '0;
        s1.st = r_q.st;
        if (req_we) s1 = apply_req(r_q.st, req_val);

        s2 = '0;
        s2.st = s1.st;
        if (run_we) s2 = apply_run(s1.st, run_val);

        r_d         = r_q;
        r_d.st      = s2.st;
        r_d.grant   = (s2.st == ST_GRANT);
        r_d.running = (s2.st == ST_RUN);
        r_d.cpu_rst = s2.cpu_rst;
        r_d.stop    = s1.stop | s2.stop;
        r_d.restart = s1.restart | s2.restart;
        r_d.fm_hold = ~s2.st[0];
        restart_now = r_d.restart;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.fm_hold <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign state   = r_q.st;
    assign grant   = r_q.grant;
    assign running = r_q.running;
    assign cpu_rst = r_q.cpu_rst;
    assign stop    = r_q.stop;
    assign restart = r_q.restart;
    assign fm_hold = r_q.fm_hold;

    p_req_sets_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_we && req_val && !run_we) |=> state[1]);

    p_req_clears_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_we && !req_val && !run_we) |=> !state[1]);

    p_hold_clears_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_we && !run_val) |=> (!state[0] && fm_hold));

    p_no_rst_when_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_we && run_val && state[0]) |=> !cpu_rst);

    p_grant_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant) |-> $past(req_we || run_we));

    p_rst_one_clk_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst |=> !cpu_rst);

    p_stop_one_clk_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !stop);

endmodule

// File: rtl/snd_arb_align.sv
module snd_arb_align #(
    parameter int CW   = 20,
    parameter int STEP = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart_now,
    input  logic [CW-1:0] cycle_now,
    output logic [CW:0] resume_cycle
);

    localparam int OW = CW + 1;

    logic [OW-1:0] ext;
    logic [OW-1:0] quo;
    logic [OW-1:0] rounded;
    logic [OW-1:0] val_d, val_q;

    always_comb begin
        ext     = {1'b0, cycle_now} + OW'(STEP - 1);
        quo     = ext / OW'(STEP);
        rounded = quo * OW'(STEP);
        val_d   = restart_now ? rounded : val_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign resume_cycle = val_q;

    p_hold_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_now |=> $stable(resume_cycle));

endmodule

// File: rtl/snd_arb_gate.sv
module snd_arb_gate #(
    parameter int            DW         = 8,
    parameter logic [DW-1:0] OPEN_VALUE = '1
) (
    input  logic          grant,
    input  logic [DW-1:0] snd_rd_data,
    input  logic          host_wr_en,
    output logic [DW-1:0] host_rd_data,
    output logic          snd_wr_en
);

    always_comb begin
        host_rd_data = grant ? snd_rd_data : OPEN_VALUE;
        snd_wr_en    = grant & host_wr_en;
    end

endmodule

// File: rtl/snd_bus_arbiter.sv
module snd_bus_arbiter
    import snd_arb_pkg::*;
#(
    parameter int            CW         = 20,
    parameter int            DW         = 8,
    parameter int            STEP       = 15,
    parameter logic [DW-1:0] OPEN_VALUE = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_we,
    input  logic          req_val,
    input  logic          run_we,
    input  logic          run_val,
    input  logic [CW-1:0] cycle_now,
    input  logic [DW-1:0] snd_rd_data,
    input  logic          host_wr_en,
    output logic [DW-1:0] host_rd_data,
    output logic          snd_wr_en,
    output logic [1:0]    arb_state,
    output logic          host_grant,
    output logic          snd_running,
    output logic          snd_cpu_rst,
    output logic          fm_rst,
    output logic          fm_hold,
    output logic          snd_stop,
    output logic          resume_pulse,
    output logic [CW:0]   resume_cycle
);

    logic    restart_now;
    arb_st_t st;

    snd_arb_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_we      (req_we),
        .req_val     (req_val),
        .run_we      (run_we),
        .run_val     (run_val),
        .restart_now (restart_now),
        .state       (st),
        .grant       (host_grant),
        .running     (snd_running),
        .cpu_rst     (snd_cpu_rst),
        .stop        (snd_stop),
        .restart     (resume_pulse),
        .fm_hold     (fm_hold)
    );

    snd_arb_align #(.CW(CW), .STEP(STEP)) u_align (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart_now  (restart_now),
        .cycle_now    (cycle_now),
        .resume_cycle (resume_cycle)
    );

    snd_arb_gate #(.DW(DW), .OPEN_VALUE(OPEN_VALUE)) u_gate (
        .grant        (host_grant),
        .snd_rd_data  (snd_rd_data),
        .host_wr_en   (host_wr_en),
        .host_rd_data (host_rd_data),
        .snd_wr_en    (snd_wr_en)
    );

    assign arb_state = st;
    assign fm_rst    = snd_cpu_rst;

    p_round_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |-> ((32'(resume_cycle) % STEP) == 0
                          && 32'(resume_cycle) >= 32'($past(cycle_now))
                          && 32'(resume_cycle) <  32'($past(cycle_now)) + STEP));

    p_no_write_ungranted_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_GRANT) |-> !snd_wr_en);

    p_resume_one_clk_r12: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |=> !resume_pulse);

endmodule

// File: tb/snd_bus_arbiter_test.sv
`timescale 1ns/100ps
module snd_bus_arbiter_test;

    localparam int CW = 20;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_we = 0, req_val = 0, run_we = 0, run_val = 0;
    logic [CW-1:0] cycle_now = '0;
    logic [DW-1:0] snd_rd_data = '0;
    logic          host_wr_en = 0;
    logic [DW-1:0] host_rd_data;
    logic          snd_wr_en;
    logic [1:0]    arb_state;
    logic          host_grant, snd_running, snd_cpu_rst, fm_rst, fm_hold;
    logic          snd_stop, resume_pulse;
    logic [CW:0]   resume_cycle;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    snd_bus_arbiter uut (
        .clk(clk), .rst_n(rst_n),
        .req_we(req_we), .req_val(req_val), .run_we(run_we), .run_val(run_val),
        .cycle_now(cycle_now), .snd_rd_data(snd_rd_data), .host_wr_en(host_wr_en),
        .host_rd_data(host_rd_data), .snd_wr_en(snd_wr_en), .arb_state(arb_state),
        .host_grant(host_grant), .snd_running(snd_running), .snd_cpu_rst(snd_cpu_rst),
        .fm_rst(fm_rst), .fm_hold(fm_hold), .snd_stop(snd_stop),
        .resume_pulse(resume_pulse), .resume_cycle(resume_cycle)
    );

    typedef struct packed {
        logic        hw, hv, rw, rv;
        logic [19:0] cyc;
        logic [1:0]  st;
        logic        gr, crst, stp, res, fmh;
        logic [20:0] rc;
    } vec_t;

    // sequence from state 0; rc only checked when res is set
    localparam vec_t TBL [13] = '{
        '{1'b0,1'b0,1'b1,1'b1, 20'd7,   2'd1, 1'b0,1'b1,1'b0,1'b1,1'b0, 21'd15},  // R5
        '{1'b1,1'b1,1'b0,1'b0, 20'd100, 2'd3, 1'b1,1'b0,1'b1,1'b0,1'b0, 21'd0},   // R2
        '{1'b1,1'b0,1'b0,1'b0, 20'd150, 2'd1, 1'b0,1'b0,1'b0,1'b1,1'b0, 21'd150}, // R3
        '{1'b1,1'b0,1'b0,1'b0, 20'd151, 2'd1, 1'b0,1'b0,1'b0,1'b0,1'b0, 21'd0},   // R3
        '{1'b0,1'b0,1'b1,1'b1, 20'd200, 2'd1, 1'b0,1'b0,1'b0,1'b0,1'b0, 21'd0},   // R7
        '{1'b0,1'b0,1'b1,1'b0, 20'd210, 2'd0, 1'b0,1'b0,1'b1,1'b0,1'b1, 21'd0},   // R8
        '{1'b1,1'b1,1'b0,1'b0, 20'd220, 2'd2, 1'b0,1'b0,1'b0,1'b0,1'b1, 21'd0},   // R2
        '{1'b0,1'b0,1'b1,1'b1, 20'd230, 2'd3, 1'b1,1'b1,1'b0,1'b0,1'b0, 21'd0},   // R6
        '{1'b0,1'b0,1'b1,1'b0, 20'd240, 2'd2, 1'b0,1'b0,1'b0,1'b0,1'b1, 21'd0},   // R8
        '{1'b1,1'b0,1'b0,1'b0, 20'd250, 2'd0, 1'b0,1'b0,1'b0,1'b0,1'b1, 21'd0},   // R3
        '{1'b1,1'b1,1'b1,1'b1, 20'd301, 2'd3, 1'b1,1'b1,1'b0,1'b0,1'b0, 21'd0},   // R11
        '{1'b1,1'b0,1'b1,1'b0, 20'd400, 2'd0, 1'b0,1'b0,1'b1,1'b1,1'b1, 21'd405}, // R11
        '{1'b0,1'b0,1'b0,1'b0, 20'd500, 2'd0, 1'b0,1'b0,1'b0,1'b0,1'b1, 21'd0}    // R12
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic hw, hv, rw, rv, input logic [CW-1:0] c);
        @(negedge clk);
        req_we = hw; req_val = hv; run_we = rw; run_val = rv; cycle_now = c;
        @(negedge clk);
        req_we = 0; run_we = 0;
    endtask

    task automatic round_case(input logic [CW-1:0] c, input logic [20:0] exp);
        drive(1'b0, 1'b0, 1'b1, 1'b0, '0);       // back to state 0
        drive(1'b0, 1'b0, 1'b1, 1'b1, c);        // restart from 0
        chk("R4 resume pulse", 32'(resume_pulse), 32'd1);
        chk("R4 rounded cycle", 32'(resume_cycle), 32'(exp));
    endtask

    initial begin : watchdog
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 state", 32'(arb_state), 32'd0);
        chk("R1 grant", 32'(host_grant), 32'd0);
        chk("R1 fm_hold", 32'(fm_hold), 32'd1);
        chk("R1 pulses", 32'({snd_cpu_rst, fm_rst, snd_stop, resume_pulse}), 32'd0);
        chk("R1 resume_cycle", 32'(resume_cycle), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 13; i++) begin
            drive(TBL[i].hw, TBL[i].hv, TBL[i].rw, TBL[i].rv, TBL[i].cyc);
            chk($sformatf("R9 state v%0d", i), 32'(arb_state), 32'(TBL[i].st));
            chk($sformatf("R9 grant v%0d", i), 32'(host_grant), 32'(TBL[i].gr));
            chk($sformatf("R5 cpu_rst v%0d", i), 32'(snd_cpu_rst), 32'(TBL[i].crst));
            chk($sformatf("R6 fm_rst v%0d", i), 32'(fm_rst), 32'(TBL[i].crst));
            chk($sformatf("R8 stop v%0d", i), 32'(snd_stop), 32'(TBL[i].stp));
            chk($sformatf("R3 resume v%0d", i), 32'(resume_pulse), 32'(TBL[i].res));
            chk($sformatf("R8 fm_hold v%0d", i), 32'(fm_hold), 32'(TBL[i].fmh));
            chk($sformatf("R9 running v%0d", i), 32'(snd_running), 32'(TBL[i].st == 2'd1));
            if (TBL[i].res)
                chk($sformatf("R4 cycle v%0d", i), 32'(resume_cycle), 32'(TBL[i].rc));
        end

        // R12 pulses fall after one clock
        drive(1'b0, 1'b0, 1'b1, 1'b1, 20'd600);
        chk("R12 rst high", 32'(snd_cpu_rst), 32'd1);
        @(negedge clk);
        chk("R12 rst low", 32'({snd_cpu_rst, fm_rst, resume_pulse}), 32'd0);

        // R10 open bus while ungranted (state 1 now)
        snd_rd_data = 8'h5A; host_wr_en = 1'b1;
        #1;
        chk("R10 open read", 32'(host_rd_data), 32'hFF);
        chk("R10 write blocked", 32'(snd_wr_en), 32'd0);
        host_wr_en = 1'b0;
        drive(1'b1, 1'b1, 1'b0, 1'b0, 20'd700);   // 1 -> 3
        snd_rd_data = 8'h3C; host_wr_en = 1'b1;
        #1;
        chk("R10 granted read", 32'(host_rd_data), 32'h3C);
        chk("R10 granted write", 32'(snd_wr_en), 32'd1);
        host_wr_en = 1'b0;
        drive(1'b1, 1'b0, 1'b0, 1'b0, 20'd750);   // 3 -> 1
        chk("R10 regrant dropped", 32'(host_rd_data), 32'hFF);
        // R4 hold between pulses
        chk("R4 value 750", 32'(resume_cycle), 32'd750);
        @(negedge clk);
        chk("R4 value kept", 32'(resume_cycle), 32'd750);

        // R4 rounding boundaries
        round_case(20'd0, 21'd0);
        round_case(20'd15, 21'd15);
        round_case(20'd16, 21'd30);
        round_case(20'd1048574, 21'd1048575);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule